// File: doc/BRIEF.md
# SRAM Histogram Increment Engine

This engine turns an external synchronous SRAM of 65,536 words by 32 bits into a large bank of event counters or histogram bins. When an event is reported, the engine builds a 16-bit SRAM address from a source chosen with the event. It reads the word at that address, adds one, and writes the sum back. The whole read-modify-write takes three cycles with the default pipeline depth.

One address source stores a service time in compressed form. A 12-bit cycle count is first reduced to a 7-bit minifloat, with a 3-bit exponent and a 4-bit mantissa, so that a wide range of latencies fits in a histogram of modest size. The host processor can also read and write SRAM words directly, for example to clear bins or collect results. An increment that wraps a word past its maximum raises a maskable interrupt. The engine handles one update at a time. An event that arrives while it is busy is dropped and tallied.

Top module: `hist_incr_engine`

## Requirements
- R1: After reset, `busy`, `irq`, `sram_we`, `sram_oe` and `lost_cnt` are all zero.
- R2: A host write stores `host_wdata` at word `host_addr[17:2]`. A host read of that word returns it on `host_rdata` in the cycle `host_ack` is high. `host_req` is held until `host_ack`.
- R3: An accepted event adds one to the addressed word. `busy` is high for exactly PIPE_STAGES+2 cycles (3 by default), starting the cycle after acceptance.
- R4: Source 1 (`evt_src`=1) addresses `{evt_state[2:0], evt_req[1:0], evt_xphase[10:0]}`, with the state bits most significant.
- R5: Source 3 addresses `{evt_xphase[3:0], evt_svc[11:0]}`. Source 0 addresses `host_addr[17:2]`.
- R6: Source 2 addresses `{evt_state, evt_req, evt_xphase[3:0], code[6:0]}`, where `code` is the minifloat form of `evt_svc`.
- R7: Minifloat `code` = {exp[2:0], man[3:0]}. It decodes to `man` when exp=0, and to `(16+man) << (exp-1)` otherwise. The encoder picks the largest code whose value does not exceed the count. Counts above 1984 give 7'h7F.
- R8: Incrementing the word 32'hFFFFFFFF writes 0 and sets a sticky overflow flag. `irq` equals flag AND NOT `irq_mask`. `irq_clr` clears the flag.
- R9: An event presented while `busy` is high is dropped, and its word stays unchanged. Each drop adds one to `lost_cnt`, which saturates at its maximum.
- R10: Address, write enable, output enable and write data reach the SRAM through the same PIPE_STAGES registers. Write enable and output enable are never high together.
- R11: If an event and a host request arrive in the same idle cycle, the event is served first. The host request is served after the event completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event strobe |
| evt_src | input | 2 | Address source select for the event |
| evt_state | input | 3 | State field |
| evt_req | input | 2 | Request-type field |
| evt_xphase | input | 11 | Extended phase identifier (low 4 bits form the phase) |
| evt_svc | input | 12 | Service time in cycles |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 32 | Host byte address, word in bits [17:2] |
| host_wdata | input | 32 | Host write data |
| host_ack | output | 1 | Host access complete |
| host_rdata | output | 32 | Host read data, valid with host_ack |
| sram_addr | output | 16 | SRAM address |
| sram_we | output | 1 | SRAM write enable |
| sram_oe | output | 1 | SRAM output (read) enable |
| sram_wdata | output | 32 | SRAM write data |
| sram_rdata | input | 32 | SRAM read data, one cycle after a read is presented |
| busy | output | 1 | Update or host access in progress |
| irq_mask | input | 1 | Masks the overflow interrupt when high |
| irq_clr | input | 1 | Clears the overflow flag |
| irq | output | 1 | Overflow interrupt |
| lost_cnt | output | 16 | Saturating count of dropped events |

## Verification
Some properties are checked on every cycle by assertions. Read and write enables never overlap at the SRAM. A busy interval never exceeds its bound. The interrupt never shows while masked. The lost-event tally never decreases, and it grows by one for every event that meets a busy engine.

Other behaviours can only be shown by the bench's scenarios, through host reads of the SRAM afterwards. These are:
- the address packing of each source;
- the minifloat codes at the boundaries and at saturation;
- increment arithmetic and the wrap on overflow;
- the order of service when an event and a host request collide;
- that a dropped event leaves its bin untouched.

// File: rtl/hist_pkg.sv
package hist_pkg;
   localparam int ST_W   = 3;
   localparam int RQ_W   = 2;
   localparam int XPH_W  = 11;
   localparam int PH_W   = 4;
   localparam int SVC_W  = 12;
   localparam int EXP_W  = 3;
   localparam int MAN_W  = 4;
   localparam int CODE_W = EXP_W + MAN_W;
   localparam int SRC_W  = 2;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RD,
      S_WT,
      S_WR,
      S_HWR
   } eng_state_e;
endpackage

// File: rtl/svc_minifloat_enc.sv
module svc_minifloat_enc #(
   parameter int SVC_W = 12,
   parameter int EXP_W = 3,
   parameter int MAN_W = 4
) (
   input  logic [SVC_W-1:0]       cycles,
   output logic [EXP_W+MAN_W-1:0] code
);
   localparam int MAX_EXP = (1 << EXP_W) - 1;
   localparam int TOP_BIT = MAN_W + MAX_EXP - 1;

   if (MAN_W < 1 || EXP_W < 1) begin : g_bad_fmt
      $error("svc_minifloat_enc: exponent and mantissa need at least one bit");
   end
   if (SVC_W <= MAN_W) begin : g_bad_w
      $error("svc_minifloat_enc: count narrower than mantissa");
   end

   int               msb_pos;
   logic [SVC_W-1:0] shifted;

   always_comb begin
      msb_pos = -1;
      for (int i = 0; i < SVC_W; i++) begin
         if (cycles[i]) msb_pos = i;
      end
      shifted = '0;
      if (msb_pos < MAN_W) begin
         code = {{EXP_W{1'b0}}, cycles[MAN_W-1:0]};
      end else if (msb_pos > TOP_BIT) begin
         code = '1;
      end else begin
         shifted = cycles >> (msb_pos - MAN_W);
         code    = {EXP_W'(msb_pos - MAN_W + 1), shifted[MAN_W-1:0]};
      end
   end
endmodule

// File: rtl/hist_addr_mux.sv
module hist_addr_mux
   import hist_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [SRC_W-1:0]  src,
   input  logic [ADDR_W-1:0] host_word,
   input  logic [ST_W-1:0]   st,
   input  logic [RQ_W-1:0]   rq,
   input  logic [XPH_W-1:0]  xph,
   input  logic [SVC_W-1:0]  svc,
   input  logic [CODE_W-1:0] svc_code,
   output logic [ADDR_W-1:0] addr
);
   if (ST_W + RQ_W + XPH_W != ADDR_W) begin : g_chk1
      $error("hist_addr_mux: source 1 fields do not fill the address");
   end
   if (ST_W + RQ_W + PH_W + CODE_W != ADDR_W) begin : g_chk2
      $error("hist_addr_mux: source 2 fields do not fill the address");
   end
   if (PH_W + SVC_W != ADDR_W) begin : g_chk3
      $error("hist_addr_mux: source 3 fields do not fill the address");
   end

   always_comb begin
      case (src)
         2'd1:    addr = {st, rq, xph};
         2'd2:    addr = {st, rq, xph[PH_W-1:0], svc_code};
         2'd3:    addr = {xph[PH_W-1:0], svc};
         default: addr = host_word;
      endcase
   end
endmodule

// File: rtl/sram_cmd_pipe.sv
module sram_cmd_pipe #(
   parameter int W      = 50,
   parameter int STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0) begin : g_bad
      $error("sram_cmd_pipe: negative depth");
   end

   if (STAGES == 0) begin : g_direct
      assign q = d;
   end else begin : g_regs
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end
endmodule

// File: rtl/hist_incr_engine.sv
module hist_incr_engine
   import hist_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int HOST_AW     = 32,
   parameter int PIPE_STAGES = 1,
   parameter int LOST_W      = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt_valid,
   input  logic [SRC_W-1:0]   evt_src,
   input  logic [ST_W-1:0]    evt_state,
   input  logic [RQ_W-1:0]    evt_req,
   input  logic [XPH_W-1:0]   evt_xphase,
   input  logic [SVC_W-1:0]   evt_svc,
   input  logic               host_req,
   input  logic               host_we,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic               host_ack,
   output logic [DATA_W-1:0]  host_rdata,
   output logic [ADDR_W-1:0]  sram_addr,
   output logic               sram_we,
   output logic               sram_oe,
   output logic [DATA_W-1:0]  sram_wdata,
   input  logic [DATA_W-1:0]  sram_rdata,
   output logic               busy,
   input  logic               irq_mask,
   input  logic               irq_clr,
   output logic               irq,
   output logic [LOST_W-1:0]  lost_cnt
);
   localparam int CMD_W  = ADDR_W + 2 + DATA_W;
   localparam int WAIT_W = (PIPE_STAGES > 1) ? $clog2(PIPE_STAGES) : 1;

   if (ADDR_W != 16) begin : g_chk_addr
      $error("hist_incr_engine: address fields are laid out for 16 bits");
   end
   if (HOST_AW < ADDR_W + 2) begin : g_chk_host
      $error("hist_incr_engine: host address too narrow for word index");
   end
   if (LOST_W < 1 || DATA_W < 2) begin : g_chk_misc
      $error("hist_incr_engine: bad counter widths");
   end

   eng_state_e        state_q;
   logic              op_host_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] hwdata_q;
   logic [WAIT_W-1:0] wait_q;
   logic              ovf_q;
   logic [LOST_W-1:0] lost_q;

   logic [ADDR_W-1:0] host_word;
   logic [CODE_W-1:0] svc_code;
   logic [ADDR_W-1:0] evt_addr;
   logic              idle, evt_take, host_take, evt_drop, wrap;

   assign host_word = host_addr[ADDR_W+1:2];
   assign idle      = (state_q == S_IDLE);
   assign evt_take  = evt_valid && idle;
   assign host_take = host_req && !evt_valid && idle;
   assign evt_drop  = evt_valid && !idle;
   assign wrap      = (state_q == S_WR) && !op_host_q && (sram_rdata == '1);

   svc_minifloat_enc #(
      .SVC_W (SVC_W),
      .EXP_W (EXP_W),
      .MAN_W (MAN_W)
   ) enc_i (
      .cycles (evt_svc),
      .code   (svc_code)
   );

   hist_addr_mux #(
      .ADDR_W (ADDR_W)
   ) mux_i (
      .src       (evt_src),
      .host_word (host_word),
      .st        (evt_state),
      .rq        (evt_req),
      .xph       (evt_xphase),
      .svc       (evt_svc),
      .svc_code  (svc_code),
      .addr      (evt_addr)
   );

   // sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         op_host_q <= 1'b0;
         addr_q    <= '0;
         hwdata_q  <= '0;
         wait_q    <= '0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (evt_take) begin
                  addr_q    <= evt_addr;
                  op_host_q <= 1'b0;
                  state_q   <= S_RD;
               end else if (host_take) begin
                  addr_q    <= host_word;
                  hwdata_q  <= host_wdata;
                  op_host_q <= 1'b1;
                  state_q   <= host_we ? S_HWR : S_RD;
               end
            end
            S_RD: begin
               wait_q  <= '0;
               state_q <= (PIPE_STAGES == 0) ? S_WR : S_WT;
            end
            S_WT: begin
               if (wait_q == WAIT_W'(PIPE_STAGES - 1)) state_q <= S_WR;
               else wait_q <= wait_q + 1'b1;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // overflow flag and lost-event tally
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q  <= 1'b0;
         lost_q <= '0;
      end else begin
         if (wrap)         ovf_q <= 1'b1;
         else if (irq_clr) ovf_q <= 1'b0;
         if (evt_drop && lost_q != '1) lost_q <= lost_q + 1'b1;
      end
   end

   // command formation, then a common delay line for all SRAM controls
   logic [ADDR_W-1:0] c_addr;
   logic              c_we, c_oe;
   logic [DATA_W-1:0] c_wdata;

   always_comb begin
      c_addr  = '0;
      c_we    = 1'b0;
      c_oe    = 1'b0;
      c_wdata = '0;
      case (state_q)
         S_RD: begin
            c_addr = addr_q;
            c_oe   = 1'b1;
         end
         S_WR: begin
            if (!op_host_q) begin
               c_addr  = addr_q;
               c_we    = 1'b1;
               c_wdata = sram_rdata + 1'b1;
            end
         end
         S_HWR: begin
            c_addr  = addr_q;
            c_we    = 1'b1;
            c_wdata = hwdata_q;
         end
         default: ;
      endcase
   end

   logic [CMD_W-1:0] cmd_d, cmd_q;
   assign cmd_d = {c_addr, c_we, c_oe, c_wdata};

   sram_cmd_pipe #(
      .W      (CMD_W),
      .STAGES (PIPE_STAGES)
   ) pipe_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmd_d),
      .q     (cmd_q)
   );

   assign {sram_addr, sram_we, sram_oe, sram_wdata} = cmd_q;

   assign host_ack   = ((state_q == S_WR) && op_host_q) || (state_q == S_HWR);
   assign host_rdata = ((state_q == S_WR) && op_host_q) ? sram_rdata : '0;
   assign busy       = !idle;
   assign irq        = ovf_q && !irq_mask;
   assign lost_cnt   = lost_q;
endmodule

// File: rtl/hist_incr_engine_chk.sv
module hist_incr_engine_chk #(
   parameter int PIPE_STAGES = 1,
   parameter int LOST_W      = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_valid,
   input logic              busy,
   input logic              sram_we,
   input logic              sram_oe,
   input logic              irq,
   input logic              irq_mask,
   input logic [LOST_W-1:0] lost_cnt
);
   logic [7:0] busy_run;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy) busy_run <= '0;
      else if (busy_run != '1) busy_run <= busy_run + 1'b1;
   end

   p_no_rw_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(sram_we && sram_oe));

   p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mask |-> !irq);

   p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_run <= 8'(PIPE_STAGES + 1)));

   p_lost_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (lost_cnt >= $past(lost_cnt)));

   p_drop_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && busy) |=>
         ((lost_cnt == $past(lost_cnt) + 1'b1) || ($past(lost_cnt) == '1)));
endmodule

bind hist_incr_engine hist_incr_engine_chk #(
   .PIPE_STAGES (PIPE_STAGES),
   .LOST_W      (LOST_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_valid (evt_valid),
   .busy      (busy),
   .sram_we   (sram_we),
   .sram_oe   (sram_oe),
   .irq       (irq),
   .irq_mask  (irq_mask),
   .lost_cnt  (lost_cnt)
);

// File: tb/hist_incr_engine_tb_top.sv
`timescale 1ns/1ps
module hist_incr_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [1:0]  evt_src = '0;
   logic [2:0]  evt_state = '0;
   logic [1:0]  evt_req = '0;
   logic [10:0] evt_xphase = '0;
   logic [11:0] evt_svc = '0;
   logic        host_req = 1'b0;
   logic        host_we = 1'b0;
   logic [31:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic        host_ack;
   logic [31:0] host_rdata;
   logic [15:0] sram_addr;
   logic        sram_we, sram_oe;
   logic [31:0] sram_wdata;
   logic [31:0] sram_rdata = '0;
   logic        busy;
   logic        irq_mask = 1'b0;
   logic        irq_clr = 1'b0;
   logic        irq;
   logic [15:0] lost_cnt;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   hist_incr_engine dut_i (
      .clk, .rst_n, .evt_valid, .evt_src, .evt_state, .evt_req,
      .evt_xphase, .evt_svc, .host_req, .host_we, .host_addr,
      .host_wdata, .host_ack, .host_rdata, .sram_addr, .sram_we,
      .sram_oe, .sram_wdata, .sram_rdata, .busy, .irq_mask, .irq_clr,
      .irq, .lost_cnt
   );

   // behavioural SRAM: read data one cycle after the read is presented
   logic [31:0] mem [int unsigned];
   always @(posedge clk) begin
      if (sram_oe) sram_rdata <= mem.exists(32'(sram_addr)) ? mem[32'(sram_addr)] : 32'h0;
      if (sram_we) mem[32'(sram_addr)] = sram_wdata;
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_write(logic [15:0] word, logic [31:0] data);
      @(negedge clk);
      host_req = 1'b1; host_we = 1'b1;
      host_addr = {14'b0, word, 2'b0}; host_wdata = data;
      for (int i = 0; i < 20 && !host_ack; i++) @(negedge clk);
      host_req = 1'b0; host_we = 1'b0;
   endtask

   task automatic host_read(logic [15:0] word, output logic [31:0] data);
      @(negedge clk);
      host_req = 1'b1; host_we = 1'b0;
      host_addr = {14'b0, word, 2'b0};
      data = 32'hDEAD_BEEF;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (host_ack) begin
            data = host_rdata;
            break;
         end
      end
      host_req = 1'b0;
   endtask

   task automatic fire(logic [1:0] src, logic [2:0] st, logic [1:0] rq,
                       logic [10:0] xph, logic [11:0] svc, output int busy_cycles);
      @(negedge clk);
      evt_src = src; evt_state = st; evt_req = rq; evt_xphase = xph; evt_svc = svc;
      evt_valid = 1'b1;
      busy_cycles = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         evt_valid = 1'b0;
         if (busy) busy_cycles++;
      end
   endtask

   task automatic t_reset();
      chk("R1 busy", 32'(busy), 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 sram_we", 32'(sram_we), 0);
      chk("R1 sram_oe", 32'(sram_oe), 0);
      chk("R1 lost_cnt", 32'(lost_cnt), 0);
   endtask

   task automatic t_host_rw();
      logic [31:0] d;
      host_write(16'h1234, 32'hCAFE_0001);
      host_write(16'hFFFF, 32'h0BAD_F00D);
      host_read(16'h1234, d);
      chk("R2 host read 1234", d, 32'hCAFE_0001);
      host_read(16'hFFFF, d);
      chk("R2 host read FFFF", d, 32'h0BAD_F00D);
   endtask

   task automatic t_src1();
      logic [31:0] d;
      int bc;
      host_write(16'hB3A5, 32'd41);
      fire(2'd1, 3'd5, 2'd2, 11'h3A5, 12'h000, bc);
      chk("R3 busy length", 32'(bc), 3);
      host_read(16'hB3A5, d);
      chk("R4 src1 bin incremented", d, 32'd42);
      fire(2'd1, 3'd5, 2'd2, 11'h3A5, 12'h000, bc);
      host_read(16'hB3A5, d);
      chk("R3 second increment", d, 32'd43);
   endtask

   task automatic t_src3_src0();
      logic [31:0] d;
      int bc;
      fire(2'd3, 3'd7, 2'd3, 11'h7F9, 12'hABC, bc);
      host_read(16'h9ABC, d);
      chk("R5 src3 bin", d, 32'd1);
      @(negedge clk);
      host_addr = {14'b0, 16'h0440, 2'b0};
      fire(2'd0, 3'd0, 2'd0, 11'h0, 12'h0, bc);
      host_read(16'h0440, d);
      chk("R5 src0 bin", d, 32'd1);
   endtask

   task automatic t_src2_codes();
      logic [31:0] d;
      int bc;
      fire(2'd2, 3'd3, 2'd1, 11'h006, 12'd5, bc);
      host_read(16'h6B05, d);
      chk("R7 code denormal 5", d, 32'd1);
      fire(2'd2, 3'd3, 2'd1, 11'h006, 12'd16, bc);
      host_read(16'h6B10, d);
      chk("R7 code 16 -> 10h", d, 32'd1);
      fire(2'd2, 3'd3, 2'd1, 11'h006, 12'd37, bc);
      host_read(16'h6B22, d);
      chk("R7 code 37 -> 22h", d, 32'd1);
      fire(2'd2, 3'd3, 2'd1, 11'h006, 12'd1000, bc);
      host_read(16'h6B6F, d);
      chk("R6 code 1000 -> 6Fh", d, 32'd1);
      fire(2'd2, 3'd3, 2'd1, 11'h006, 12'd2047, bc);
      host_read(16'h6B7F, d);
      chk("R7 code 2047 saturates", d, 32'd1);
      fire(2'd2, 3'd3, 2'd1, 11'h006, 12'd3000, bc);
      host_read(16'h6B7F, d);
      chk("R7 code 3000 saturates", d, 32'd2);
   endtask

   task automatic t_overflow();
      logic [31:0] d;
      int bc;
      host_write(16'h1ABC, 32'hFFFF_FFFF);
      fire(2'd3, 3'd0, 2'd0, 11'h001, 12'hABC, bc);
      host_read(16'h1ABC, d);
      chk("R8 wrap to zero", d, 32'd0);
      chk("R8 irq raised", 32'(irq), 1);
      @(negedge clk); irq_mask = 1'b1;
      @(negedge clk);
      chk("R8 irq masked", 32'(irq), 0);
      irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0; irq_mask = 1'b0;
      @(negedge clk);
      chk("R8 irq cleared", 32'(irq), 0);
   endtask

   task automatic t_lost();
      logic [31:0] d;
      host_write(16'h2001, 32'd10);
      host_write(16'h2002, 32'd7);
      @(negedge clk);
      evt_src = 2'd3; evt_xphase = 11'h002; evt_svc = 12'h001; evt_valid = 1'b1;
      @(negedge clk);
      evt_svc = 12'h002;
      @(negedge clk);
      evt_valid = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9 lost count", 32'(lost_cnt), 1);
      host_read(16'h2002, d);
      chk("R9 dropped bin unchanged", d, 32'd7);
      host_read(16'h2001, d);
      chk("R9 accepted bin", d, 32'd11);
   endtask

   task automatic t_priority();
      logic [31:0] d;
      host_write(16'h3055, 32'd100);
      @(negedge clk);
      evt_src = 2'd3; evt_xphase = 11'h003; evt_svc = 12'h055; evt_valid = 1'b1;
      host_req = 1'b1; host_we = 1'b0; host_addr = {14'b0, 16'h3055, 2'b0};
      d = 32'hDEAD_BEEF;
      @(negedge clk);
      evt_valid = 1'b0;
      chk("R11 host not served first", 32'(host_ack), 0);
      for (int i = 0; i < 20; i++) begin
         if (host_ack) begin d = host_rdata; break; end
         @(negedge clk);
      end
      host_req = 1'b0;
      chk("R11 host sees event result", d, 32'd101);
      chk("R9 no drop on same-cycle host", 32'(lost_cnt), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_host_rw();
      t_src1();
      t_src3_src0();
      t_src2_codes();
      t_overflow();
      t_lost();
      t_priority();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule